// File: doc/BRIEF.md
# Random Number Generator Control Front End

This block sits between a simple register bus and a pseudo-random word source. Software writes a small control word to start generation, to turn on strict underflow reporting, to mask the error interrupt and to acknowledge it. Once generation is started, a first-in first-out buffer of random words fills at one word per clock until it is full. Software then pulls words through a data-read address. A 32-bit Galois linear-feedback shift register, started from a nonzero seed, stands in for the entropy source.

A data read that finds the buffer empty returns zero and raises an error. The error drives an interrupt line unless it is masked. When strict reporting is on, the same event also latches a security-violation flag that only a hardware reset clears. The start and strict-reporting bits cannot be cleared by software once they are set. A read-only status word reports the error flags, the current fill level and the buffer depth.

Bus timing: a request with write enable low returns its read data combinationally in the same cycle. Every side effect of an access takes place at the clock edge that ends it: a write, a pop, or the flags set by an underflow.

Top module: `rng_ctrl_top`

## Requirements
- R1: After reset the control word (address 0) reads 0, the status word (address 1) reads 0x0010_0000 and the interrupt output is low.
- R2: Control bits 31..4 are reserved. They read as zero and writes to them are ignored. The acknowledge bit 3 always reads back as zero.
- R3: Control bit 0 (start) is sticky. Once written as one, a later write of zero leaves it set until hardware reset.
- R4: Control bit 1 (strict reporting) is sticky. Once written as one, a later write of zero leaves it set until hardware reset.
- R5: Control bit 2 (mask) gates the interrupt. The interrupt output is high exactly when status bit 2 (error pending) is set and the mask is clear.
- R6: A control write with bit 3 set clears status bit 2 at that edge. A control write with bit 3 clear leaves status bit 2 unchanged.
- R7: A read of address 2 while the buffer is empty returns zero and sets status bit 1 (last read underflowed) and status bit 2.
- R8: Status bit 0 (security violation) is set by an empty read only while control bit 1 is set. Once set, it stays set through acknowledges until reset.
- R9: While control bit 0 is set and the buffer is not full, one word is added per clock. The fill level in status bits 15..8 rises by one per cycle and stops at the depth.
- R10: Words read from address 2 follow the generator sequence from the seed. Each next word is the previous one shifted right by one, XORed with 0xA300_0000 when the bit shifted out was one.
- R11: A read of address 2 that finds the buffer non-empty clears status bit 1.
- R12: Status bits 23..16 report the buffer depth, 16 by default. Bits 31..24 and 7..3 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| bus_req | input | 1 | Access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 control, 1 status, 2 data, 3 reads zero |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the request cycle |
| irq_o | output | 1 | Error interrupt, active high |

## Verification
The bench sweeps control writes that set every low bit on its own, together with writes that set all reserved bits. Reading back after each write separates stored bits, sticky bits and strobe bits. Empty-buffer reads are made once with strict reporting off and once with it on, under each mask setting, which separates the error flag, the violation flag and the interrupt gating. After generation starts, the fill level is sampled on consecutive cycles and again after saturation, which tells a one-word-per-cycle fill from a stalled or overrunning one. A run of back-to-back reads longer than the buffer is compared against the generator sequence computed in the bench; this checks word order across the pointer wrap while refills happen at the same time.

// File: rtl/rng_pkg.sv
package rng_pkg;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_STATUS = 2'd1,
    REG_DATA   = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic go;
    logic ha;
    logic im;
  } ctrl_t;

  typedef struct packed {
    logic sv;
    logic uf;
    logic err;
  } flags_t;

  localparam int unsigned CTRL_GO_BIT = 0;
  localparam int unsigned CTRL_HA_BIT = 1;
  localparam int unsigned CTRL_IM_BIT = 2;
  localparam int unsigned CTRL_CI_BIT = 3;

  function automatic logic [31:0] lfsr_step(input logic [31:0] s, input logic [31:0] poly);
    logic [31:0] n;
    n = s >> 1;
    if (s[0]) n = n ^ poly;
    return n;
  endfunction

  function automatic logic [31:0] pack_ctrl(input ctrl_t c);
    logic [31:0] w;
    w = '0;
    w[CTRL_GO_BIT] = c.go;
    w[CTRL_HA_BIT] = c.ha;
    w[CTRL_IM_BIT] = c.im;
    return w;
  endfunction

  function automatic logic [31:0] pack_status(input flags_t f, input logic [7:0] level,
                                              input logic [7:0] depth);
    return {8'h00, depth, level, 5'b00000, f.err, f.uf, f.sv};
  endfunction

endpackage

// File: rtl/rng_lfsr.sv
module rng_lfsr #(
  parameter int unsigned      W    = 32,
  parameter logic [W-1:0]     POLY = 32'hA300_0000,
  parameter logic [W-1:0]     SEED = 32'hACE1_2468
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         advance,
  output logic [W-1:0] value
);
  logic [W-1:0] state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state_q <= SEED;
    else if (advance) state_q <= rng_pkg::lfsr_step(state_q, POLY);
  end

  assign value = state_q;
endmodule

// File: rtl/rng_fifo.sv
module rng_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [LW-1:0] level,
  output logic          empty,
  output logic          full
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [LW-1:0] level_q;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr_q] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (push) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({push, pop})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  assign head  = mem[rd_ptr_q];
  assign level = level_q;
  assign empty = (level_q == '0);
  assign full  = (level_q == LW'(DEPTH));
endmodule

// File: rtl/rng_regs.sv
module rng_regs
  import rng_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic [3:0] ctrl_wbits,
  input  logic       good_read,
  input  logic       empty_read,
  output ctrl_t      ctrl,
  output flags_t     flags,
  output logic       ack_ev
);
  ctrl_t  ctrl_q;
  flags_t flags_q;

  assign ack_ev = ctrl_wr & ctrl_wbits[CTRL_CI_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q.go <= ctrl_q.go | ctrl_wbits[CTRL_GO_BIT];
      ctrl_q.ha <= ctrl_q.ha | ctrl_wbits[CTRL_HA_BIT];
      ctrl_q.im <= ctrl_wbits[CTRL_IM_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else begin
      if (empty_read) begin
        flags_q.uf  <= 1'b1;
        flags_q.err <= 1'b1;
        if (ctrl_q.ha) flags_q.sv <= 1'b1;
      end else begin
        if (good_read) flags_q.uf  <= 1'b0;
        if (ack_ev)    flags_q.err <= 1'b0;
      end
    end
  end

  assign ctrl  = ctrl_q;
  assign flags = flags_q;
endmodule

// File: rtl/rng_ctrl_top.sv
module rng_ctrl_top
  import rng_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter logic [31:0] POLY  = 32'hA300_0000,
  parameter logic [31:0] SEED  = 32'hACE1_2468
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_req,
  input  logic        bus_we,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq_o
);
  localparam int unsigned LW = $clog2(DEPTH + 1);
  localparam logic [7:0]  DEPTH8 = 8'(DEPTH);

  reg_sel_e sel;
  assign sel = reg_sel_e'(bus_addr);

  // named internal events, also used by the bound checker
  logic ctrl_wr_ev, data_rd_ev, pop_ev, underflow_ev, push_ev, ack_ev;
  logic fifo_empty, fifo_full;
  logic [LW-1:0] fifo_level;
  logic [31:0] fifo_head, rand_word;
  ctrl_t  ctrl;
  flags_t flags;

  logic unused_wbits;
  assign unused_wbits = ^bus_wdata[31:4];

  assign ctrl_wr_ev   = bus_req & bus_we & (sel == REG_CTRL);
  assign data_rd_ev   = bus_req & ~bus_we & (sel == REG_DATA);
  assign pop_ev       = data_rd_ev & ~fifo_empty;
  assign underflow_ev = data_rd_ev & fifo_empty;
  assign push_ev      = ctrl.go & ~fifo_full;

  rng_lfsr #(.W(32), .POLY(POLY), .SEED(SEED)) u_lfsr (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (push_ev),
    .value   (rand_word)
  );

  rng_fifo #(.W(32), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push_ev),
    .push_data (rand_word),
    .pop       (pop_ev),
    .head      (fifo_head),
    .level     (fifo_level),
    .empty     (fifo_empty),
    .full      (fifo_full)
  );

  rng_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr_ev),
    .ctrl_wbits (bus_wdata[3:0]),
    .good_read  (pop_ev),
    .empty_read (underflow_ev),
    .ctrl       (ctrl),
    .flags      (flags),
    .ack_ev     (ack_ev)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_req && !bus_we) begin
      case (sel)
        REG_CTRL:   bus_rdata = pack_ctrl(ctrl);
        REG_STATUS: bus_rdata = pack_status(flags, 8'(fifo_level), DEPTH8);
        REG_DATA:   bus_rdata = fifo_empty ? '0 : fifo_head;
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign irq_o = flags.err & ~ctrl.im;
endmodule

// File: rtl/rng_ctrl_chk.sv
module rng_ctrl_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          go,
  input logic          ha,
  input logic          im,
  input logic          err,
  input logic          uf,
  input logic          sv,
  input logic          irq,
  input logic          push_ev,
  input logic          pop_ev,
  input logic          underflow_ev,
  input logic          ack_ev,
  input logic          full,
  input logic [LW-1:0] level,
  input logic [31:0]   rdata
);
  a_r3_go_sticky: assert property (@(posedge clk) disable iff (!rst_n) go |=> go);
  a_r4_ha_sticky: assert property (@(posedge clk) disable iff (!rst_n) ha |=> ha);
  a_r5_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n) im |-> !irq);
  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ev && !underflow_ev) |=> !err);
  a_r7_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_ev |-> (rdata == 32'h0));
  a_r7_empty_read_flags: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_ev |=> (err && uf));
  a_r8_viol_needs_strict: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sv) |-> $past(ha));
  a_r8_viol_sticky: assert property (@(posedge clk) disable iff (!rst_n) sv |=> sv);
  a_r9_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push_ev);
  a_r9_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));
  a_r9_fill_step: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ev && !pop_ev) |=> (level == $past(level) + 1'b1));
  a_r11_good_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ev |=> !uf);
endmodule

bind rng_ctrl_top rng_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .go           (ctrl.go),
  .ha           (ctrl.ha),
  .im           (ctrl.im),
  .err          (flags.err),
  .uf           (flags.uf),
  .sv           (flags.sv),
  .irq          (irq_o),
  .push_ev      (push_ev),
  .pop_ev       (pop_ev),
  .underflow_ev (underflow_ev),
  .ack_ev       (ack_ev),
  .full         (fifo_full),
  .level        (fifo_level),
  .rdata        (bus_rdata)
);

// File: tb/rng_ctrl_top_tb_top.sv
`timescale 1ns/1ps
module rng_ctrl_top_tb_top;
  localparam logic [31:0] POLY = 32'hA300_0000;
  localparam logic [31:0] SEED = 32'hACE1_2468;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rng_ctrl_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // status word written out field by field
  function automatic logic [31:0] exp_status(int lvl, bit err, bit uf, bit sv);
    return (32'd16 * 32'h1_0000) + (32'(lvl) * 32'h100) + (err ? 32'd4 : 0)
           + (uf ? 32'd2 : 0) + (sv ? 32'd1 : 0);
  endfunction

  function automatic logic [31:0] next_word(logic [31:0] s);
    logic [31:0] r;
    r = {1'b0, s[31:1]};
    if (s[0] == 1'b1) r = r ^ POLY;
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_req = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 20000);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [31:0] model;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, v); check("R1 ctrl", v, 32'h0);
    rd(2'd1, v); check("R1 status", v, exp_status(0, 0, 0, 0));
    check("R1 irq", {31'h0, irq_o}, 32'h0);
    // R12 depth field and zero fields
    check("R12 depth", v, 32'h0010_0000);

    // R2 reserved bits and the acknowledge bit read zero
    wr(2'd0, 32'hFFFF_FFF4); rd(2'd0, v); check("R2 reserved", v, 32'h4);
    wr(2'd0, 32'hFFFF_FFFC); rd(2'd0, v); check("R2 ack reads zero", v, 32'h4);
    rd(2'd3, v); check("R2 unused address", v, 32'h0);

    // R7 empty read, strict off, masked
    rd(2'd2, v); check("R7 empty data", v, 32'h0);
    rd(2'd1, v); check("R7 flags", v, exp_status(0, 1, 1, 0));
    check("R8 no viol without strict", v & 32'h1, 32'h0);
    check("R5 masked irq", {31'h0, irq_o}, 32'h0);

    // R5 unmask
    wr(2'd0, 32'h0);
    check("R5 unmasked irq", {31'h0, irq_o}, 32'h1);
    // R6 write with ack clear has no effect
    wr(2'd0, 32'h0); rd(2'd1, v); check("R6 ack zero no effect", v, exp_status(0, 1, 1, 0));
    wr(2'd0, 32'h8); rd(2'd1, v); check("R6 ack clears", v, exp_status(0, 0, 1, 0));
    check("R6 irq after ack", {31'h0, irq_o}, 32'h0);

    // R4 strict sticky
    wr(2'd0, 32'h2); rd(2'd0, v); check("R4 set", v, 32'h2);
    wr(2'd0, 32'h0); rd(2'd0, v); check("R4 sticky", v, 32'h2);

    // R8 empty read with strict on
    rd(2'd2, v); check("R7 empty data strict", v, 32'h0);
    rd(2'd1, v); check("R8 viol set", v, exp_status(0, 1, 1, 1));
    check("R5 irq pending", {31'h0, irq_o}, 32'h1);
    wr(2'd0, 32'h8); rd(2'd1, v); check("R8 viol survives ack", v, exp_status(0, 0, 1, 1));

    // R9 fill one word per cycle
    wr(2'd0, 32'h1);
    @(posedge clk);
    rd(2'd1, v); check("R9 level 1", v, exp_status(1, 0, 1, 1));
    rd(2'd1, v); check("R9 level 2", v, exp_status(2, 0, 1, 1));
    rd(2'd1, v); check("R9 level 3", v, exp_status(3, 0, 1, 1));
    repeat (30) @(posedge clk);
    rd(2'd1, v); check("R9 saturates", v, exp_status(16, 0, 1, 1));
    rd(2'd0, v); check("R3 go set", v, 32'h3);
    wr(2'd0, 32'h0); rd(2'd0, v); check("R3 go sticky", v, 32'h3);

    // R10 sequence across wrap, back-to-back reads
    model = SEED;
    for (int i = 0; i < 40; i++) begin
      rd(2'd2, v);
      check($sformatf("R10 word %0d", i), v, model);
      model = next_word(model);
    end
    rd(2'd1, v); check("R11 uf cleared", v & 32'hFFFF_00FF, 32'h0010_0001);

    // R2 im still writable with sticky bits held
    wr(2'd0, 32'hF0F4); rd(2'd0, v); check("R2 ctrl mixed", v, 32'h7);

    finish_run();
  end
endmodule